// File: doc/BRIEF.md
# Addressable-LED Pixel Wire Encoder

This block converts a stream of 24-bit colour pixels into the slot pattern that a chain of single-wire addressable LEDs expects. Each colour bit becomes a three-slot symbol: every symbol starts high and ends low, and the middle slot carries the data bit. A downstream shift-register serializer sends one slot per third of an LED bit period. The slots are packed into 32-bit words for that serializer's FIFO. The block sends the green channel first, so pixels can arrive in ordinary red-green-blue layout.

Pixels arrive over a valid/ready handshake, and a last marker closes a frame. The block moves one colour byte at a time into a 64-slot accumulator and emits a word whenever 32 slots are pending. When the frame closes, the block zero-fills the partial word and appends one more all-zero word, so the line rests low. It then pulses a done flag. A parameter caps the number of words in a frame. Pixels that would break the cap are accepted and then discarded.

Top module: `pixel_wire_enc`

## Requirements
- R1: `pix_data` holds red in bits 23:16, green in bits 15:8 and blue in bits 7:0. The block sends the channels in the order green, red, blue, and each channel most significant bit first.
- R2: A data bit of 1 becomes the slots 1,1,0 and a data bit of 0 becomes the slots 1,0,0, in time order.
- R3: Slots fill each output word from bit 31 down to bit 0. A pixel's 72 slots continue across word boundaries, with no gap between pixels.
- R4: After the last pixel of a frame, any unfilled slots of the current word are 0, and then one further word of value 0 follows. A frame whose slot count is a multiple of 32 gets only that extra word.
- R5: With k kept pixels, a frame holds ceil(72k/32)+1 words. A pixel is kept only if that total stays at or below MAX_WORDS. Any other pixel is accepted and discarded, but its last marker still closes the frame. Each frame starts its count of kept pixels from zero.
- R6: While `word_valid` is high and `word_ready` is low, the next cycle keeps `word_valid` high and `word_data` unchanged.
- R7: From the cycle after a last-marked pixel is accepted until the cycle of the `frame_done` pulse, `pix_ready` is low.
- R8: After reset, `word_count` is 0. It rises by one in the cycle after each accepted output word, and returns to 0 in the cycle after `frame_done`.
- R9: `frame_done` is high for exactly one cycle: the cycle after the frame's final zero word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Input pixel present |
| pix_data | input | 24 | Pixel colour, red 23:16, green 15:8, blue 7:0 |
| pix_last | input | 1 | Pixel closes the frame |
| pix_ready | output | 1 | Block accepts a pixel this cycle |
| word_valid | output | 1 | Output word present |
| word_data | output | 32 | Packed slots, first slot in bit 31 |
| word_ready | input | 1 | Downstream takes the word this cycle |
| word_count | output | $clog2(MAX_WORDS+1) | Words accepted so far in the current frame |
| frame_done | output | 1 | One-cycle pulse after a frame's final word |

## Verification
The properties assume a downstream that holds `word_ready` as a plain level sampled at the clock, and a source whose `pix_data` and `pix_last` are meaningful only when `pix_valid` is high. The bench changes every input one nanosecond after the rising edge and holds each pixel until it sees `pix_ready`, so every transfer happens at a single clean edge. To exercise R6, the bench throttles `word_ready` with a pseudo-random sequence, which creates long and short stalls, including stalls during padding. The stimulus includes a frame that overruns the word cap, including a dropped pixel that carries the last marker, and a frame that ends exactly on a word boundary.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

    typedef enum logic [1:0] {
        PK_RUN   = 2'd0,
        PK_DRAIN = 2'd1,
        PK_TAIL  = 2'd2
    } pk_state_e;

    // Three slots per data bit: high, data, low; earliest slot in the top position.
    function automatic logic [23:0] expand_byte(input logic [7:0] b);
        logic [23:0] s;
        s = '0;
        for (int i = 0; i < 8; i++) begin
            s[23 - 3*i] = 1'b1;
            s[22 - 3*i] = b[7 - i];
            s[21 - 3*i] = 1'b0;
        end
        return s;
    endfunction

    // Input is {red, green, blue}; the wire wants {green, red, blue}.
    function automatic logic [23:0] to_wire_order(input logic [23:0] rgb);
        return {rgb[15:8], rgb[23:16], rgb[7:0]};
    endfunction

endpackage

// File: rtl/pwe_pixel_stage.sv
module pwe_pixel_stage
    import pwe_pkg::*;
#(
    parameter int MAX_PIX = 6,
    localparam int KW = (MAX_PIX < 1) ? 1 : $clog2(MAX_PIX + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pix_valid,
    input  logic [23:0] pix_data,
    input  logic        pix_last,
    output logic        pix_ready,
    input  logic        packer_busy,
    input  logic        byte_take,
    output logic        byte_valid,
    output logic [23:0] byte_slots,
    output logic        end_pending,
    input  logic        end_ack
);

    typedef struct packed {
        logic [23:0]   grb;
        logic [1:0]    left;
        logic          end_flag;
        logic [KW-1:0] kept;
    } stage_t;

    stage_t st_d, st_q;
    logic   keep_room;

    assign keep_room   = (int'(st_q.kept) < MAX_PIX);
    assign pix_ready   = (st_q.left == 2'd0) && !st_q.end_flag && !packer_busy;
    assign byte_valid  = (st_q.left != 2'd0);
    assign byte_slots  = expand_byte(st_q.grb[23:16]);
    assign end_pending = st_q.end_flag && (st_q.left == 2'd0);

    always_comb begin
        st_d = st_q;
        if (byte_take) begin
            st_d.grb  = {st_q.grb[15:0], 8'h00};
            st_d.left = st_q.left - 2'd1;
        end
        if (pix_valid && pix_ready) begin
            if (keep_room) begin
                st_d.grb  = to_wire_order(pix_data);
                st_d.left = 2'd3;
                st_d.kept = st_q.kept + KW'(1);
            end
            st_d.end_flag = pix_last;
        end
        if (end_ack) begin
            st_d.end_flag = 1'b0;
            st_d.kept     = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwe_slot_packer.sv
module pwe_slot_packer
    import pwe_pkg::*;
#(
    parameter int MAX_WORDS = 16,
    localparam int CW = $clog2(MAX_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_valid,
    input  logic [23:0]   byte_slots,
    output logic          byte_take,
    input  logic          end_pending,
    output logic          end_ack,
    output logic          busy,
    output logic          word_valid,
    output logic [31:0]   word_data,
    input  logic          word_ready,
    output logic [CW-1:0] word_count,
    output logic          frame_done
);

    typedef struct packed {
        logic [63:0]   acc;
        logic [6:0]    cnt;
        pk_state_e     st;
        logic [CW-1:0] count;
        logic          done;
    } pack_t;

    pack_t pk_d, pk_q;
    logic  pop;

    assign word_valid = (pk_q.cnt >= 7'd32);
    assign word_data  = pk_q.acc[63:32];
    assign word_count = pk_q.count;
    assign frame_done = pk_q.done;
    assign busy       = (pk_q.st != PK_RUN);
    assign pop        = word_valid && word_ready;
    assign byte_take  = byte_valid && (pk_q.st == PK_RUN) && (pk_q.cnt <= 7'd40);

    always_comb begin
        pk_d      = pk_q;
        pk_d.done = 1'b0;
        end_ack   = 1'b0;
        if (pk_q.done) begin
            pk_d.count = '0;
        end
        if (pop) begin
            pk_d.acc   = {pk_q.acc[31:0], 32'h0};
            pk_d.cnt   = pk_q.cnt - 7'd32;
            pk_d.count = pk_d.count + CW'(1);
        end
        if (byte_take) begin
            pk_d.acc = pk_d.acc | ({byte_slots, 40'h0} >> pk_d.cnt);
            pk_d.cnt = pk_d.cnt + 7'd24;
        end
        unique case (pk_q.st)
            PK_RUN: begin
                if (end_pending) begin
                    end_ack = 1'b1;
                    if (pk_d.cnt[4:0] != 5'd0) begin
                        pk_d.cnt = {pk_d.cnt[6:5] + 2'd1, 5'd0};
                    end
                    pk_d.st = PK_DRAIN;
                end
            end
            PK_DRAIN: begin
                if (pk_d.cnt == 7'd0) begin
                    pk_d.cnt = 7'd32;
                    pk_d.st  = PK_TAIL;
                end
            end
            PK_TAIL: begin
                if (pk_d.cnt == 7'd0) begin
                    pk_d.done = 1'b1;
                    pk_d.st   = PK_RUN;
                end
            end
            default: pk_d.st = PK_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pk_q    <= '0;
            pk_q.st <= PK_RUN;
        end else begin
            pk_q <= pk_d;
        end
    end

endmodule

// File: rtl/pixel_wire_enc.sv
module pixel_wire_enc #(
    parameter int MAX_WORDS = 16,
    localparam int CW      = $clog2(MAX_WORDS + 1),
    localparam int MAX_PIX = ((MAX_WORDS - 1) * 32) / 72
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic [23:0]   pix_data,
    input  logic          pix_last,
    output logic          pix_ready,
    output logic          word_valid,
    output logic [31:0]   word_data,
    input  logic          word_ready,
    output logic [CW-1:0] word_count,
    output logic          frame_done
);

    logic        busy;
    logic        byte_take;
    logic        byte_valid;
    logic [23:0] byte_slots;
    logic        end_pending;
    logic        end_ack;

    pwe_pixel_stage #(.MAX_PIX(MAX_PIX)) stage_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .pix_last   (pix_last),
        .pix_ready  (pix_ready),
        .packer_busy(busy),
        .byte_take  (byte_take),
        .byte_valid (byte_valid),
        .byte_slots (byte_slots),
        .end_pending(end_pending),
        .end_ack    (end_ack)
    );

    pwe_slot_packer #(.MAX_WORDS(MAX_WORDS)) packer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_slots (byte_slots),
        .byte_take  (byte_take),
        .end_pending(end_pending),
        .end_ack    (end_ack),
        .busy       (busy),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_ready (word_ready),
        .word_count (word_count),
        .frame_done (frame_done)
    );

endmodule

// File: rtl/pwe_checker.sv
module pwe_checker #(
    parameter int MAX_WORDS = 16,
    localparam int CW = $clog2(MAX_WORDS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_valid,
    input logic          pix_last,
    input logic          pix_ready,
    input logic          word_valid,
    input logic [31:0]   word_data,
    input logic          word_ready,
    input logic [CW-1:0] word_count,
    input logic          frame_done
);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

    assert_last_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready && pix_last) |=> !pix_ready);

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready) |=> (word_count == CW'($past(word_count) + CW'(1))));

    assert_count_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (word_count == '0));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_done_after_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(word_valid && word_ready && (word_data == 32'h0)));

    assert_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(word_count) <= MAX_WORDS);

endmodule

bind pixel_wire_enc pwe_checker #(.MAX_WORDS(MAX_WORDS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_last  (pix_last),
    .pix_ready (pix_ready),
    .word_valid(word_valid),
    .word_data (word_data),
    .word_ready(word_ready),
    .word_count(word_count),
    .frame_done(frame_done)
);

// File: tb/pixel_wire_enc_tb_top.sv
`timescale 1ns/1ps
module pixel_wire_enc_tb_top;
    localparam int MAXW = 16;
    localparam int MAXP = ((MAXW - 1) * 32) / 72;
    localparam int CW   = $clog2(MAXW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_valid = 1'b0;
    logic [23:0]   pix_data = '0;
    logic          pix_last = 1'b0;
    logic          pix_ready;
    logic          word_valid;
    logic [31:0]   word_data;
    logic          word_ready = 1'b0;
    logic [CW-1:0] word_count;
    logic          frame_done;

    always #2 clk = ~clk;

    pixel_wire_enc #(.MAX_WORDS(MAXW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_last(pix_last), .pix_ready(pix_ready), .word_valid(word_valid),
        .word_data(word_data), .word_ready(word_ready), .word_count(word_count),
        .frame_done(frame_done)
    );

    int    vectors = 0;
    int    fails   = 0;
    int    cyc     = 0;
    string cur_tag = "R1";
    bit    stall_mode = 1'b0;
    bit    ready_on   = 1'b0;
    int    lfsr = 32'h1ACE;

    // reference model state
    bit          bitq[$];
    int          endq[$];
    int          queued_words = 0;
    int          popped = 0;
    int          kept_m = 0;
    int          frame_bits = 0;
    int          cnt_m = 0;
    bit          done_exp = 1'b0;
    bit          in_pad = 1'b0;
    bit          hold_prev = 1'b0;
    logic [31:0] hold_data = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        #1;
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 32'h0);
        word_ready = ready_on && (!stall_mode || lfsr[0] || lfsr[3]);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit new_done;
            chk(int'(word_count) == cnt_m, "R8 word_count", 32'(word_count), 32'(cnt_m));
            chk(frame_done == done_exp, "R9 frame_done", 32'(frame_done), 32'(done_exp));
            if (in_pad) chk(pix_ready == 1'b0, "R7 pix_ready", 32'(pix_ready), 32'd0);
            if (hold_prev) chk(word_valid && word_data == hold_data, "R6 stall hold", word_data, hold_data);
            hold_prev = word_valid && !word_ready;
            hold_data = word_data;
            new_done = 1'b0;
            if (done_exp) cnt_m = 0;
            if (word_valid && word_ready) begin
                logic [31:0] exp;
                exp = '0;
                if (bitq.size() < 32) begin
                    chk(1'b0, {cur_tag, " unexpected word"}, word_data, 32'h0);
                end else begin
                    for (int k = 0; k < 32; k++) exp[31 - k] = bitq.pop_front();
                    chk(word_data == exp, {cur_tag, " word_data"}, word_data, exp);
                end
                cnt_m++;
                popped++;
                if (endq.size() > 0 && popped == endq[0]) begin
                    void'(endq.pop_front());
                    new_done = 1'b1;
                    in_pad = 1'b0;
                end
            end
            if (pix_valid && pix_ready) begin
                if (kept_m < MAXP) begin
                    logic [23:0] col;
                    col = {pix_data[15:8], pix_data[23:16], pix_data[7:0]};
                    for (int j = 23; j >= 0; j--) begin
                        bitq.push_back(1'b1);
                        bitq.push_back(col[j]);
                        bitq.push_back(1'b0);
                    end
                    frame_bits += 72;
                    kept_m++;
                end
                if (pix_last) begin
                    while ((frame_bits % 32) != 0) begin
                        bitq.push_back(1'b0);
                        frame_bits++;
                    end
                    for (int k = 0; k < 32; k++) bitq.push_back(1'b0);
                    frame_bits += 32;
                    queued_words += frame_bits / 32;
                    endq.push_back(queued_words);
                    frame_bits = 0;
                    kept_m = 0;
                    in_pad = 1'b1;
                end
            end
            done_exp = new_done;
        end
    end

    task automatic send_pixel(input logic [23:0] d, input bit l);
        pix_valid = 1'b1;
        pix_data  = d;
        pix_last  = l;
        do @(negedge clk); while (!pix_ready);
        @(posedge clk);
        #1;
        pix_valid = 1'b0;
    endtask

    task automatic send_frame(input int n, input int seed, input bit gaps);
        for (int i = 0; i < n; i++) begin
            send_pixel(24'((seed * 32'h9E3779B1) ^ (i * 32'h00A5C31)), i == n - 1);
            if (gaps) repeat (i % 3) begin @(posedge clk); #1; end
        end
    endtask

    task automatic drain();
        int t;
        t = 0;
        while ((bitq.size() != 0 || endq.size() != 0 || done_exp) && t < 5000) begin
            @(posedge clk);
            #1;
            t++;
        end
        repeat (3) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(word_valid == 1'b0, "R8 reset word_valid", 32'(word_valid), 32'd0);
        chk(word_count == '0, "R8 reset word_count", 32'(word_count), 32'd0);
        chk(frame_done == 1'b0, "R9 reset frame_done", 32'(frame_done), 32'd0);
        chk(pix_ready == 1'b1, "R7 reset pix_ready", 32'(pix_ready), 32'd1);
        @(posedge clk);
        #1;
        ready_on = 1'b1;

        cur_tag = "R1";
        send_pixel(24'h123456, 1'b1);
        drain();
        send_pixel(24'hF00F81, 1'b1);
        drain();

        cur_tag = "R2";
        send_pixel(24'hFFFFFF, 1'b0);
        send_pixel(24'h000000, 1'b1);
        drain();

        cur_tag = "R3";
        send_frame(5, 3, 1'b1);
        drain();
        send_frame(3, 7, 1'b0);
        drain();

        cur_tag = "R4";
        send_frame(4, 11, 1'b0);
        drain();
        send_frame(1, 12, 1'b1);
        drain();

        cur_tag = "R5";
        send_frame(9, 21, 1'b0);
        drain();
        send_frame(MAXP + 1, 22, 1'b1);
        drain();
        send_frame(2, 23, 1'b0);
        drain();

        cur_tag = "R6";
        stall_mode = 1'b1;
        send_frame(6, 31, 1'b0);
        send_frame(2, 32, 1'b1);
        send_frame(4, 33, 1'b0);
        drain();
        stall_mode = 1'b0;

        chk(bitq.size() == 0, "R4 leftover slots", 32'(bitq.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule